// File: doc/BRIEF.md
# Packed SIMD Absolute-Value Adder

This execution unit handles one packed-vector instruction on 128-bit operands. For every element, it forms the absolute value of the element from the first operand and the absolute value of the matching element from the second operand. It then adds the two. Each element is computed on its own, and the sum wraps at the element width. The element width is 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 lanes. The width is chosen at run time from a field of the instruction word.

The unit receives a valid strobe, a 32-bit instruction word and the two operand vectors, which the register file has already read out. It checks whether the word belongs to the absolute-add group and picks the element width. One clock later it presents the result vector, the destination register index and a valid flag. A small two-state output controller drives the valid flag:
- `OUT_IDLE` means no result is being presented.
- `OUT_ISSUE` means a result from the previous cycle is on the outputs.
- Transition `fire`: from either state to `OUT_ISSUE` when a valid, matching word arrives.
- Transition `quiet`: from either state to `OUT_IDLE` otherwise.
- Reset forces `OUT_IDLE`.

Top module: `simd_absadd`

## Requirements
- R1: `out_valid` is 1 in the cycle after an edge where `in_valid` was 1 and `instr[31:17]` equalled 15'b011100000101110. Otherwise it is 0.
- R2: `instr[16:15]` selects the element width: 2'b00 is 8 bits (16 lanes), 2'b01 is 16 bits (8 lanes), 2'b10 is 32 bits (4 lanes), 2'b11 is 64 bits (2 lanes). Lane k occupies bits [k*W +: W].
- R3: Each lane is abs(a) + abs(b). Lanes are treated as signed two's complement: a lane with its top bit set is negated, and any other lane is used as is.
- R4: The most negative lane value negates to itself. For example, abs(8'h80) is 8'h80, so 8'h80 + 8'h80 gives 8'h00 in a byte lane.
- R5: Each lane sum is taken modulo 2^W. No carry passes into the next lane.
- R6: `out_dst` takes `instr[4:0]` of the accepted word. Bits 14:10 and 9:5 name the sources and do not affect the result.
- R7: The result appears exactly one cycle after the word is accepted.
- R8: A word that is not valid or does not match leaves `out_result` and `out_dst` unchanged and gives `out_valid` = 0.
- R9: A synchronous reset clears `out_valid` and `out_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Registered result is valid |
| out_dst | output | 5 | Destination register index |
| out_result | output | 128 | Registered lane-wise result |

## Verification
The assertions assume the inputs carry known values at every rising edge. They also assume that reset is held for at least one edge before any instruction is offered. The stimulus keeps to this in three ways: it drives every input only on falling edges, it holds reset low only after the first edges have passed, and it drives `in_valid` and the operands to defined values during reset. Random words are split between the matching group and near-miss encodings, which differ in one bit of the group field. This exercises the decode boundary without undefined input bits.

// File: rtl/aa_pkg.sv
package aa_pkg;
    localparam int VEC_W   = 128;
    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int NUM_SZ  = 4;
    localparam int KEY_W   = 15;
    localparam logic [KEY_W-1:0] GROUP_KEY = 15'b011100000101110;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } lane_sz_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_ISSUE = 1'b1
    } out_state_e;

    typedef struct packed {
        logic             hit;
        lane_sz_e         size;
        logic [REG_W-1:0] dst;
    } insn_dec_t;
endpackage

// File: rtl/aa_decode.sv
module aa_decode
    import aa_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output insn_dec_t         dec
);
    logic unused_src_fields;

    assign unused_src_fields = ^instr[14:5];

    always_comb begin
        dec.hit  = (instr[31:17] == GROUP_KEY);
        dec.size = lane_sz_e'(instr[16:15]);
        dec.dst  = instr[4:0];
    end
endmodule

// File: rtl/aa_lane.sv
module aa_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;

    always_comb begin
        mag_a = a[W-1] ? (~a + {{(W-1){1'b0}}, 1'b1}) : a;
        mag_b = b[W-1] ? (~b + {{(W-1){1'b0}}, 1'b1}) : b;
        y     = mag_a + mag_b;
    end
endmodule

// File: rtl/aa_slice.sv
module aa_slice #(
    parameter int VW = 128,
    parameter int W  = 8
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    localparam int LANES = VW / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        aa_lane #(.W(W)) u_lane (
            .a (a[i*W +: W]),
            .b (b[i*W +: W]),
            .y (y[i*W +: W])
        );
    end
endmodule

// File: rtl/simd_absadd.sv
module simd_absadd
    import aa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [127:0]      src_a,
    input  logic [127:0]      src_b,
    output logic              out_valid,
    output logic [4:0]        out_dst,
    output logic [127:0]      out_result
);
    insn_dec_t                    dec;
    logic [NUM_SZ-1:0][VEC_W-1:0] cand;
    logic [VEC_W-1:0]             picked;
    logic                         fire;
    out_state_e                   state_q;
    out_state_e                   state_d;

    aa_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_width
        aa_slice #(.VW(VEC_W), .W(8 << k)) u_slice (
            .a (src_a),
            .b (src_b),
            .y (cand[k])
        );
    end

    always_comb begin
        unique case (dec.size)
            SZ_BYTE:  picked = cand[0];
            SZ_HALF:  picked = cand[1];
            SZ_WORD:  picked = cand[2];
            SZ_DWORD: picked = cand[3];
            default:  picked = cand[0];
        endcase
    end

    assign fire = in_valid && dec.hit;

    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = fire ? OUT_ISSUE : OUT_IDLE;
            OUT_ISSUE: state_d = fire ? OUT_ISSUE : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_dst    <= '0;
        end else if (fire) begin
            out_result <= picked;
            out_dst    <= dec.dst;
        end
    end

    assign out_valid = (state_q == OUT_ISSUE);
endmodule

// File: rtl/aa_checker.sv
module aa_checker (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [31:0]  instr,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic         out_valid,
    input logic [4:0]   out_dst,
    input logic [127:0] out_result
);
    logic accept;
    assign accept = in_valid && (instr[31:17] == 15'b011100000101110);

    function automatic logic [7:0] ref8(input logic [7:0] x, input logic [7:0] z);
        logic [7:0] mx, mz;
        mx = x[7] ? 8'(-x) : x;
        mz = z[7] ? 8'(-z) : z;
        return 8'(mx + mz);
    endfunction

    function automatic logic [63:0] ref64(input logic [63:0] x, input logic [63:0] z);
        logic [63:0] mx, mz;
        mx = x[63] ? 64'(-x) : x;
        mz = z[63] ? 64'(-z) : z;
        return 64'(mx + mz);
    endfunction

    p_valid_follows_accept_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept));

    p_accept_gives_valid_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    p_byte_lane0_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[16:15] == 2'b00) |=>
            out_result[7:0] == ref8($past(src_a[7:0]), $past(src_b[7:0])));

    p_dword_lane1_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[16:15] == 2'b11) |=>
            out_result[127:64] == ref64($past(src_a[127:64]), $past(src_b[127:64])));

    p_dst_capture_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_dst == $past(instr[4:0]));

    p_hold_on_reject_r8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(out_result) && $stable(out_dst) && !out_valid));

    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind simd_absadd aa_checker u_chk (.*);

// File: tb/test_simd_absadd.sv
module test_simd_absadd;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         out_valid;
    logic [4:0]   out_dst;
    logic [127:0] out_result;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit done       = 1'b0;

    logic         m_valid;
    logic [4:0]   m_dst;
    logic [127:0] m_res;

    localparam logic [14:0] KEY = 15'b011100000101110;

    always #5 clk = ~clk;

    simd_absadd i_simd_absadd (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_dst(out_dst), .out_result(out_result)
    );

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] d,
                                       input logic [4:0] sa, input logic [4:0] sb);
        return {KEY, sz, sb, sa, d};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz);
        int w;
        logic [127:0] r;
        logic [127:0] mask;
        w = 8 << sz;
        mask = (128'd1 << w) - 128'd1;
        r = '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [127:0] x, z;
            x = (a >> (i * w)) & mask;
            z = (b >> (i * w)) & mask;
            if (x[w-1]) x = (~x + 128'd1) & mask;
            if (z[w-1]) z = (~z + 128'd1) & mask;
            r = r | (((x + z) & mask) << (i * w));
        end
        return r;
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_res   <= '0;
            m_dst   <= '0;
        end else if (in_valid && instr[31:17] == KEY) begin
            m_valid <= 1'b1;
            m_res   <= model(src_a, src_b, instr[16:15]);
            m_dst   <= instr[4:0];
        end else begin
            m_valid <= 1'b0;
        end
    end

    // compare on every falling edge once the reference is defined
    always @(negedge clk) begin
        if (cycles > 1) begin
            compared++;
            if (out_valid !== m_valid) begin
                mismatched++;
                $display("FAIL R1/R8 valid: got %0b expected %0b", out_valid, m_valid);
            end
            compared++;
            if (out_result !== m_res) begin
                mismatched++;
                $display("FAIL R3 result: got %h expected %h", out_result, m_res);
            end
            compared++;
            if (out_dst !== m_dst) begin
                mismatched++;
                $display("FAIL R6 dst: got %0d expected %0d", out_dst, m_dst);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] w,
                         input logic [127:0] a, input logic [127:0] b);
        in_valid = v; instr = w; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset result", out_result, 128'd0);
        rst = 1'b0;

        // R4 + R5: lane0 0x80+0x80 wraps to 0, lane1 1+1 = 2 untouched by carry
        issue(1'b1, mk(2'b00, 5'd7, 5'd1, 5'd2), 128'h0180, 128'h0180);
        check("R4/R5 byte wrap", out_result, 128'h0200);
        check("R1/R7 valid after accept", {127'd0, out_valid}, 128'd1);
        check("R6 dst", {123'd0, out_dst}, 128'd7);

        // R2: all-ones operand is -1 in every width
        issue(1'b1, mk(2'b00, 5'd1, 5'd3, 5'd4), '1, '0);
        check("R2 byte size", out_result, {16{8'h01}});
        issue(1'b1, mk(2'b01, 5'd2, 5'd3, 5'd4), '1, '0);
        check("R2 half size", out_result, {8{16'h0001}});
        issue(1'b1, mk(2'b10, 5'd3, 5'd3, 5'd4), '1, '0);
        check("R2 word size", out_result, {4{32'h00000001}});
        issue(1'b1, mk(2'b11, 5'd4, 5'd3, 5'd4), '1, '0);
        check("R2 dword size", out_result, {2{64'h1}});

        // R4 at 64 bits, R3 mixed signs at 16 bits
        issue(1'b1, mk(2'b11, 5'd5, 5'd0, 5'd0), {2{64'h8000000000000000}}, {64'h8000000000000000, 64'h5});
        check("R4 dword most negative", out_result, {64'h0, 64'h8000000000000005});
        issue(1'b1, mk(2'b01, 5'd6, 5'd9, 5'd9), 128'hFFFF, 128'h0002);
        check("R3 half mixed signs", out_result, 128'h3);

        // R6: source fields do not change the result
        issue(1'b1, mk(2'b01, 5'd6, 5'd31, 5'd17), 128'hFFFF, 128'h0002);
        check("R6 source fields ignored", out_result, 128'h3);

        // R8: invalid strobe and near-miss key leave outputs
        issue(1'b0, mk(2'b00, 5'd9, 5'd0, 5'd0), '1, '1);
        check("R8 invalid strobe result", out_result, 128'h3);
        check("R8 invalid strobe valid", {127'd0, out_valid}, 128'd0);
        issue(1'b1, mk(2'b00, 5'd9, 5'd0, 5'd0) ^ 32'h0002_0000, '1, '1);
        check("R8 near-miss result", out_result, 128'h3);
        check("R8 near-miss dst", {123'd0, out_dst}, 128'd6);

        // random traffic against the reference model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = {$urandom, $urandom} ;
            if (($urandom % 4) != 0) w[31:17] = KEY;
            else if (($urandom % 2) == 0) w[31:17] = KEY ^ (15'd1 << ($urandom % 15));
            in_valid = ($urandom % 5) != 0;
            instr = w;
            src_a = {$urandom, $urandom, $urandom, $urandom};
            src_b = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R9 mid-run reset
        issue(1'b1, mk(2'b00, 5'd3, 5'd0, 5'd0), 128'h05, 128'h06);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid-run clear result", out_result, 128'd0);
        check("R9 mid-run clear valid", {127'd0, out_valid}, 128'd0);

        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule